// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

This peripheral sits on a simple 16-bit register bus. It holds a 16x16 multiplier with four operating modes: unsigned multiply, signed multiply, unsigned accumulate and signed accumulate. Software chooses the mode through the address it uses to write the first operand. Writing the second operand runs the operation. The product or running sum is then read back as a low word, a high word and a sum-extension word. An accumulation can be seeded by writing a start value into the low result word.

A separate 32x32 multiplier takes two 32-bit operands, each written as a low half and then a high half. Writing the high half of the second operand forms a 64-bit product, which is read back as four 16-bit words.

The 16-bit mode is a four-state machine with the states M_UMUL, M_SMUL, M_UMAC and M_SMAC. A write to first-operand address 0, 1, 2 or 3 moves it from any state to M_UMUL, M_SMUL, M_UMAC or M_SMAC respectively. Every other cycle holds the current state. The 32-bit mode is a two-state machine with the states W_UNS and W_SGN. A write to address 16 moves it from either state to W_UNS, and a write to address 17 moves it to W_SGN. Reset puts the machines in M_UMUL and W_UNS.

Top module: `mmac_top`

## Requirements
- R1: A write to address 0, 1, 2 or 3 stores the data as the 16-bit first operand and selects unsigned multiply, signed multiply, unsigned accumulate or signed accumulate respectively.
- R2: A write to address 4 is the second operand and runs the selected operation; its result is readable on the cycle after the write. No other write changes the result, except the seed write of R7.
- R3: The signed modes sign-extend both 16-bit operands before multiplying. The unsigned modes zero-extend them.
- R4: Both multiply modes place the product in the result and clear the unsigned and signed accumulators. Both accumulate modes add the product to the accumulators, and the result then shows the accumulator.
- R5: Address 5 reads result bits 15:0, and address 6 reads result bits 31:16.
- R6: Address 7 reads the sum extension. It is 0x0000 in unsigned multiply. In signed multiply it is 0xFFFF when the signed result is negative and 0x0000 otherwise. In unsigned accumulate it is the carry out of the 33-bit unsigned sum, in bit 0. In signed accumulate it is 0xFFFF when the signed accumulator is negative and 0x0000 otherwise.
- R7: A write to address 5 seeds the result and both accumulators. The unsigned accumulator takes the zero-extended value and the signed accumulator takes the sign-extended value. The result takes the sign-extended value in the signed modes and the zero-extended value in the unsigned modes.
- R8: A write to address 16 (unsigned) or 17 (signed) loads bits 15:0 of the 32-bit first operand, clears its bits 31:16 and selects the 32-bit mode. A write to address 18 replaces bits 31:16 and keeps bits 15:0.
- R9: A write to address 19 loads bits 15:0 of the 32-bit second operand, clears its upper half and computes nothing. A write to address 20 supplies bits 31:16 and forms the 64-bit product. The operands are treated as unsigned or as signed according to the 32-bit mode.
- R10: Addresses 21, 22, 23 and 24 read product bits 15:0, 31:16, 47:32 and 63:48.
- R11: After reset every result reads zero, and every address not listed for reading returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read register address |
| rd_data | output | 16 | Read data, combinational from rd_addr |

## Verification
A wrong mode state shows at address 7 the same cycle it is latched. It shows in the result words on the cycle after the next address-4 write, because the operand extension and the accumulate path both depend on it. A corrupted accumulator stays hidden through any run of plain multiplies and only appears at the first accumulate that follows. The bench therefore chains accumulate steps directly, both through carry and through sign. A lost operand half in the wide section shows only in the upper or lower product words, so all four words are compared after every wide product.

// File: rtl/mmac_pkg.sv
package mmac_pkg;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {M_UMUL, M_SMUL, M_UMAC, M_SMAC} mode16_e;
    typedef enum logic {W_UNS, W_SGN} mode32_e;

    localparam logic [ADDR_W-1:0] A_OP1_UMUL = 5'd0;
    localparam logic [ADDR_W-1:0] A_OP1_SMUL = 5'd1;
    localparam logic [ADDR_W-1:0] A_OP1_UMAC = 5'd2;
    localparam logic [ADDR_W-1:0] A_OP1_SMAC = 5'd3;
    localparam logic [ADDR_W-1:0] A_OP2      = 5'd4;
    localparam logic [ADDR_W-1:0] A_RES_LO   = 5'd5;
    localparam logic [ADDR_W-1:0] A_RES_HI   = 5'd6;
    localparam logic [ADDR_W-1:0] A_SUMEXT   = 5'd7;
    localparam logic [ADDR_W-1:0] A_W1L_U    = 5'd16;
    localparam logic [ADDR_W-1:0] A_W1L_S    = 5'd17;
    localparam logic [ADDR_W-1:0] A_W1H      = 5'd18;
    localparam logic [ADDR_W-1:0] A_W2L      = 5'd19;
    localparam logic [ADDR_W-1:0] A_W2H      = 5'd20;
    localparam logic [ADDR_W-1:0] A_WRES0    = 5'd21;
    localparam int               WRES_WORDS = 4;
endpackage

// File: rtl/mmac_core16.sv
module mmac_core16
    import mmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op1_we,
    input  mode16_e       op1_mode,
    input  logic          op2_we,
    input  logic          seed_we,
    input  logic [DW-1:0] wdata,
    output logic [2*DW-1:0] res,
    output logic [DW-1:0] sumext
);
    localparam int PW   = 2 * DW;
    localparam int XW   = 2 * (DW + 1);
    localparam int ACCW = PW + GUARD;

    mode16_e mode_q, mode_d;
    logic [DW-1:0]          opa_q;
    logic [PW-1:0]          res_q, accu_q;
    logic signed [ACCW-1:0] accs_q;
    logic                   carry_q;

    logic                 sgn;
    logic signed [DW:0]   a_x, b_x;
    logic signed [XW-1:0] prod;
    logic [ACCW-1:0]      prod_ext;
    logic [PW:0]          usum;
    logic [ACCW-1:0]      ssum;
    logic [PW-1:0]        seed_z, seed_s;

    // next-state: any op1 write selects its mode
    always_comb begin
        mode_d = mode_q;
        if (op1_we) mode_d = op1_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_UMUL;
        else        mode_q <= mode_d;
    end

    always_comb begin
        sgn      = (mode_q == M_SMUL) || (mode_q == M_SMAC);
        a_x      = sgn ? $signed({opa_q[DW-1], opa_q}) : $signed({1'b0, opa_q});
        b_x      = sgn ? $signed({wdata[DW-1], wdata}) : $signed({1'b0, wdata});
        prod     = a_x * b_x;
        prod_ext = {{(ACCW-XW){prod[XW-1]}}, prod};
        usum     = {1'b0, accu_q} + {1'b0, prod[PW-1:0]};
        ssum     = accs_q + prod_ext;
        seed_z   = {{DW{1'b0}}, wdata};
        seed_s   = {{DW{wdata[DW-1]}}, wdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q   <= '0;
            res_q   <= '0;
            accu_q  <= '0;
            accs_q  <= '0;
            carry_q <= 1'b0;
        end else begin
            if (op1_we) opa_q <= wdata;
            if (op2_we) begin
                unique case (mode_q)
                    M_UMUL, M_SMUL: begin
                        res_q   <= prod[PW-1:0];
                        accu_q  <= '0;
                        accs_q  <= '0;
                        carry_q <= 1'b0;
                    end
                    M_UMAC: begin
                        res_q   <= usum[PW-1:0];
                        accu_q  <= usum[PW-1:0];
                        accs_q  <= ssum;
                        carry_q <= usum[PW];
                    end
                    M_SMAC: begin
                        res_q   <= ssum[PW-1:0];
                        accu_q  <= usum[PW-1:0];
                        accs_q  <= ssum;
                        carry_q <= usum[PW];
                    end
                endcase
            end else if (seed_we) begin
                accu_q  <= seed_z;
                accs_q  <= {{GUARD{seed_s[PW-1]}}, seed_s};
                res_q   <= sgn ? seed_s : seed_z;
                carry_q <= 1'b0;
            end
        end
    end

    // output process: sum extension per mode
    always_comb begin
        unique case (mode_q)
            M_UMUL: sumext = '0;
            M_SMUL: sumext = {DW{res_q[PW-1]}};
            M_UMAC: sumext = {{(DW-1){1'b0}}, carry_q};
            M_SMAC: sumext = {DW{accs_q[ACCW-1]}};
        endcase
        res = res_q;
    end

    a_r1_mode_latch: assert property (@(posedge clk) disable iff (!rst_n)
        op1_we |=> mode_q == $past(op1_mode));
    a_r4_mul_clears_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op2_we && (mode_q == M_UMUL || mode_q == M_SMUL)) |=> (accu_q == '0 && accs_q == '0));
    a_r7_seed_low: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && !op2_we) |=> res_q[DW-1:0] == $past(wdata));
    a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!op2_we && !seed_we) |=> $stable(res_q));
endmodule

// File: rtl/mmac_core32.sv
module mmac_core32
    import mmac_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op1l_we,
    input  logic          op1l_sgn,
    input  logic          op1h_we,
    input  logic          op2l_we,
    input  logic          op2h_we,
    input  logic [DW-1:0] wdata,
    output logic [4*DW-1:0] prod
);
    localparam int OW = 2 * DW;
    localparam int RW = 4 * DW;

    mode32_e mode_q, mode_d;
    logic [OW-1:0] op1_q, op2_q, op2_full;
    logic [RW-1:0] prod_q, prod_d;
    logic signed [OW:0] a_x, b_x;

    always_comb begin
        mode_d = mode_q;
        if (op1l_we) mode_d = op1l_sgn ? W_SGN : W_UNS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= W_UNS;
        else        mode_q <= mode_d;
    end

    always_comb begin
        op2_full = {wdata, op2_q[DW-1:0]};
        unique case (mode_q)
            W_UNS: begin
                a_x = $signed({1'b0, op1_q});
                b_x = $signed({1'b0, op2_full});
            end
            W_SGN: begin
                a_x = $signed({op1_q[OW-1], op1_q});
                b_x = $signed({op2_full[OW-1], op2_full});
            end
        endcase
        prod_d = RW'(a_x * b_x);
        prod   = prod_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op1_q  <= '0;
            op2_q  <= '0;
            prod_q <= '0;
        end else begin
            if (op1l_we)      op1_q <= {{DW{1'b0}}, wdata};
            else if (op1h_we) op1_q <= {wdata, op1_q[DW-1:0]};
            if (op2l_we)      op2_q <= {{DW{1'b0}}, wdata};
            else if (op2h_we) begin
                op2_q  <= op2_full;
                prod_q <= prod_d;
            end
        end
    end

    a_r8_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (op1h_we && !op1l_we) |=> op1_q[DW-1:0] == $past(op1_q[DW-1:0]));
    a_r8_low_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
        op1l_we |=> op1_q[OW-1:DW] == '0);
    a_r9_low_no_compute: assert property (@(posedge clk) disable iff (!rst_n)
        (op2l_we && !op2h_we) |=> $stable(prod_q));
endmodule

// File: rtl/mmac_top.sv
module mmac_top
    import mmac_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    logic    op1_we, op2_we, seed_we;
    mode16_e op1_mode;
    logic    w1l_we, w1l_sgn, w1h_we, w2l_we, w2h_we;
    logic [2*DW-1:0] res16;
    logic [DW-1:0]   sumext;
    logic [4*DW-1:0] prod64;
    logic [DW-1:0]   wword [WRES_WORDS];

    always_comb begin
        op1_we   = wr_en && (wr_addr <= A_OP1_SMAC);
        op1_mode = mode16_e'(wr_addr[1:0]);
        op2_we   = wr_en && (wr_addr == A_OP2);
        seed_we  = wr_en && (wr_addr == A_RES_LO);
        w1l_we   = wr_en && (wr_addr == A_W1L_U || wr_addr == A_W1L_S);
        w1l_sgn  = (wr_addr == A_W1L_S);
        w1h_we   = wr_en && (wr_addr == A_W1H);
        w2l_we   = wr_en && (wr_addr == A_W2L);
        w2h_we   = wr_en && (wr_addr == A_W2H);
    end

    mmac_core16 #(.DW(DW), .GUARD(GUARD)) u_c16 (
        .clk(clk), .rst_n(rst_n), .op1_we(op1_we), .op1_mode(op1_mode),
        .op2_we(op2_we), .seed_we(seed_we), .wdata(wr_data),
        .res(res16), .sumext(sumext)
    );

    mmac_core32 #(.DW(DW)) u_c32 (
        .clk(clk), .rst_n(rst_n), .op1l_we(w1l_we), .op1l_sgn(w1l_sgn),
        .op1h_we(w1h_we), .op2l_we(w2l_we), .op2h_we(w2h_we),
        .wdata(wr_data), .prod(prod64)
    );

    for (genvar g = 0; g < WRES_WORDS; g++) begin : g_wword
        assign wword[g] = prod64[g*DW +: DW];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_RES_LO)      rd_data = res16[DW-1:0];
        else if (rd_addr == A_RES_HI) rd_data = res16[2*DW-1:DW];
        else if (rd_addr == A_SUMEXT) rd_data = sumext;
        else if (rd_addr >= A_WRES0 && rd_addr < A_WRES0 + ADDR_W'(WRES_WORDS))
            rd_data = wword[2'(rd_addr - A_WRES0)];
    end

    a_r5_lo_matches_write: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_we && rd_addr == A_RES_LO) |=> rd_data == $past(wr_data) || rd_addr != A_RES_LO);
endmodule

// File: tb/tb_mmac_top.sv
module tb_mmac_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [15:0] rd_data;
    int total = 0;
    int bad = 0;

    // {op1 address, a, b, expected lo, hi, sum-extension}
    localparam logic [95:0] VEC [NV] = '{
        {16'd0, 16'h1234, 16'h5678, 16'h0060, 16'h0626, 16'h0000},
        {16'd0, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE, 16'h0000},
        {16'd1, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0000, 16'h0000},
        {16'd1, 16'h8000, 16'h0002, 16'h0000, 16'hFFFF, 16'hFFFF},
        {16'd1, 16'h7FFF, 16'h7FFF, 16'h0001, 16'h3FFF, 16'h0000},
        {16'd2, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFE, 16'h0000},
        {16'd2, 16'hFFFF, 16'hFFFF, 16'h0002, 16'hFFFC, 16'h0001},
        {16'd1, 16'h0003, 16'hFFFE, 16'hFFFA, 16'hFFFF, 16'hFFFF},
        {16'd3, 16'hFFFF, 16'h0003, 16'hFFFD, 16'hFFFF, 16'hFFFF},
        {16'd3, 16'h0002, 16'h0002, 16'h0001, 16'h0000, 16'h0000},
        {16'd0, 16'h0000, 16'hBEEF, 16'h0000, 16'h0000, 16'h0000}
    };

    mmac_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [4:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wide(input logic [4:0] a1, input logic [15:0] a1l, input logic [15:0] a1h,
                        input logic [15:0] b2l, input logic [15:0] b2h);
        wr(a1, a1l);
        wr(5'd18, a1h);
        wr(5'd19, b2l);
        wr(5'd20, b2h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset lo", 5'd5, 16'h0000);
        chk("R11 reset hi", 5'd6, 16'h0000);
        chk("R11 reset ext", 5'd7, 16'h0000);
        chk("R11 reset wide", 5'd24, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4 R5 R6: vector walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][84:80], VEC[i][79:64]);
            wr(5'd4, VEC[i][63:48]);
            chk("R5 vec lo", 5'd5, VEC[i][47:32]);
            chk("R5 vec hi", 5'd6, VEC[i][31:16]);
            chk("R6 vec ext", 5'd7, VEC[i][15:0]);
        end

        // R7: seed in unsigned accumulate, then accumulate
        wr(5'd2, 16'h0002);
        wr(5'd5, 16'h8000);
        chk("R7 seed u lo", 5'd5, 16'h8000);
        chk("R7 seed u hi", 5'd6, 16'h0000);
        wr(5'd4, 16'h0003);
        chk("R7 seed u acc lo", 5'd5, 16'h8006);
        chk("R6 seed u carry", 5'd7, 16'h0000);
        // R7: seed in signed accumulate
        wr(5'd3, 16'h0001);
        wr(5'd5, 16'h8000);
        chk("R7 seed s hi", 5'd6, 16'hFFFF);
        chk("R6 seed s ext", 5'd7, 16'hFFFF);
        wr(5'd4, 16'h0001);
        chk("R7 seed s acc lo", 5'd5, 16'h8001);
        chk("R7 seed s acc hi", 5'd6, 16'hFFFF);
        // R2: op1 write alone computes nothing; R6 ext follows mode
        wr(5'd0, 16'h0009);
        chk("R2 no compute lo", 5'd5, 16'h8001);
        chk("R6 umul ext", 5'd7, 16'h0000);

        // R9 R10: wide unsigned (2^32-1)^2
        wide(5'd16, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        chk("R10 u w0", 5'd21, 16'h0001);
        chk("R10 u w1", 5'd22, 16'h0000);
        chk("R10 u w2", 5'd23, 16'hFFFE);
        chk("R10 u w3", 5'd24, 16'hFFFF);
        // R9: wide signed (-1)*(-1)
        wide(5'd17, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        chk("R9 s w0", 5'd21, 16'h0001);
        chk("R9 s w3", 5'd24, 16'h0000);
        // R9: wide signed -2 * 3
        wide(5'd17, 16'hFFFE, 16'hFFFF, 16'h0003, 16'h0000);
        chk("R9 neg w0", 5'd21, 16'hFFFA);
        chk("R9 neg w2", 5'd23, 16'hFFFF);
        chk("R9 neg w3", 5'd24, 16'hFFFF);
        // R8: high half keeps low half
        wide(5'd16, 16'h0005, 16'h0001, 16'h0002, 16'h0000);
        chk("R8 keep w0", 5'd21, 16'h000A);
        chk("R8 keep w1", 5'd22, 16'h0002);
        // R9: low half of operand 2 alone computes nothing
        wr(5'd19, 16'h0007);
        chk("R9 low only", 5'd21, 16'h000A);
        // R8: low write clears high half (previous high was 1)
        wr(5'd16, 16'h0003);
        wr(5'd19, 16'h0002);
        wr(5'd20, 16'h0000);
        chk("R8 clear w0", 5'd21, 16'h0006);
        chk("R8 clear w1", 5'd22, 16'h0000);
        // R11: unmapped reads
        chk("R11 unmapped op2", 5'd4, 16'h0000);
        chk("R11 unmapped 30", 5'd30, 16'h0000);
        // R2: wide writes leave the 16-bit result alone
        chk("R2 wide isolation", 5'd5, 16'h8001);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule